// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit offset into a 20-bit physical address the way a real-mode processor does. It keeps four 16-bit segment registers: extra, code, stack and data. Each access names its kind. The block picks the segment register for that kind, shifts its value left by four bits, adds the offset and drops any carry beyond bit 19. The address and the selection are combinational from the stored registers and the current inputs.

The segment registers are loaded through one synchronous write port. A write becomes visible after the clock edge that performs it. An override input can steer stack-kind and data-kind accesses to any segment register. Fetches and string destinations always use their fixed segment.

Top module: `seg_addr_unit`

## Requirements
- R1: `phys_addr` equals `seg_value` × 16 plus `offset`, taken modulo 2^20. `seg_value` is the content of the segment register reported on `seg_used`.
- R2: When `kind` = 0 (fetch), the code segment (`seg_used` = 1) is used. `ovr_valid` has no effect.
- R3: When `kind` = 1 (stack) and `ovr_valid` = 0, the stack segment (`seg_used` = 2) is used.
- R4: When `kind` = 2 (data) and `ovr_valid` = 0, the data segment (`seg_used` = 3) is used.
- R5: When `kind` = 3 (string destination), the extra segment (`seg_used` = 0) is used. `ovr_valid` has no effect.
- R6: When `ovr_valid` = 1 and `kind` is 1 or 2, `seg_used` equals `ovr_sel`.
- R7: A carry out of bit 19 is dropped. With segment 0xFFFF and offset 0x0010 the address is 0x00000.
- R8: When `seg_we` = 1, the register coded by `seg_wsel` (0 extra, 1 code, 2 stack, 3 data) takes `seg_wdata` at the rising clock edge. Before that edge the old value is still seen. No other register changes.
- R9: While `rst_n` is low, and after it returns high, the code segment holds 0xFFFF and the other three segments hold 0.
- R10: A code segment of 0x1000 with offset 0 on a fetch gives physical address 0x10000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_we | input | 1 | Segment register write enable |
| seg_wsel | input | 2 | Segment register to write (0 extra, 1 code, 2 stack, 3 data) |
| seg_wdata | input | 16 | Value to write |
| offset | input | 16 | Offset within the segment |
| kind | input | 2 | Access kind (0 fetch, 1 stack, 2 data, 3 string destination) |
| ovr_valid | input | 1 | Override request |
| ovr_sel | input | 2 | Segment requested by the override |
| phys_addr | output | 20 | Physical address |
| seg_used | output | 2 | Code of the segment register used |
| seg_value | output | 16 | Content of the segment register used |

## Verification
Directed cases come first. They load each segment register with a distinct value, so a wrong selection shows up as a wrong address and not only as a wrong code. They also try every access kind with the override on and off: this separates the kinds that honour the override from the two that must ignore it. The top-of-range segment combined with large offsets checks that the carry out of bit 19 is dropped and not saturated or kept. A write followed at once by a read of the same register shows whether the new value appears only after the clock edge. A long random run then mixes writes, kinds and overrides against the reference model.

// File: rtl/seg_addr_unit.sv
module seg_addr_unit #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter logic [SEG_W-1:0] CODE_RST = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_we,
  input  logic [1:0]        seg_wsel,
  input  logic [SEG_W-1:0]  seg_wdata,
  input  logic [OFF_W-1:0]  offset,
  input  logic [1:0]        kind,
  input  logic              ovr_valid,
  input  logic [1:0]        ovr_sel,
  output logic [SEG_W+SHIFT-1:0] phys_addr,
  output logic [1:0]        seg_used,
  output logic [SEG_W-1:0]  seg_value
);
  localparam int PA_W = SEG_W + SHIFT;
  localparam int NSEG = 4;
  localparam logic [1:0] S_EXTRA = 2'd0, S_CODE = 2'd1, S_STACK = 2'd2, S_DATA = 2'd3;
  localparam logic [1:0] K_FETCH = 2'd0, K_STACK = 2'd1, K_DATA = 2'd2, K_STRDST = 2'd3;

  logic [SEG_W-1:0] seg_q [NSEG];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSEG; i++) begin
      if (!rst_n)
        seg_q[i] <= (i == int'(S_CODE)) ? CODE_RST : '0;
      else if (seg_we && seg_wsel == 2'(i))
        seg_q[i] <= seg_wdata;
    end
  end

  always_comb begin
    case (kind)
      K_FETCH: seg_used = S_CODE;
      K_STACK: seg_used = ovr_valid ? ovr_sel : S_STACK;
      K_DATA:  seg_used = ovr_valid ? ovr_sel : S_DATA;
      default: seg_used = S_EXTRA;
    endcase
  end

  assign seg_value = seg_q[seg_used];
  assign phys_addr = {seg_value, {SHIFT{1'b0}}} + {{(PA_W-OFF_W){1'b0}}, offset};
endmodule

// File: rtl/seg_addr_unit_chk.sv
module seg_addr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        seg_we,
  input logic [1:0]  seg_wsel,
  input logic [15:0] seg_wdata,
  input logic [15:0] offset,
  input logic [1:0]  kind,
  input logic        ovr_valid,
  input logic [1:0]  ovr_sel,
  input logic [19:0] phys_addr,
  input logic [1:0]  seg_used,
  input logic [15:0] seg_value
);
  p_low_nibble_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[3:0] == offset[3:0]);
  p_fetch_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    kind == 2'd0 |-> seg_used == 2'd1);
  p_stack_seg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == 2'd1 && !ovr_valid) |-> seg_used == 2'd2);
  p_data_seg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == 2'd2 && !ovr_valid) |-> seg_used == 2'd3);
  p_strdst_extra_r5: assert property (@(posedge clk) disable iff (!rst_n)
    kind == 2'd3 |-> seg_used == 2'd0);
  p_override_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_valid && (kind == 2'd1 || kind == 2'd2)) |-> seg_used == ovr_sel);
  p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seg_we |=> (seg_used != $past(seg_wsel) || seg_value == $past(seg_wdata)));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !seg_we |=> (seg_used != $past(seg_used) || seg_value == $past(seg_value)));
endmodule

bind seg_addr_unit seg_addr_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_wsel(seg_wsel),
  .seg_wdata(seg_wdata), .offset(offset), .kind(kind), .ovr_valid(ovr_valid),
  .ovr_sel(ovr_sel), .phys_addr(phys_addr), .seg_used(seg_used),
  .seg_value(seg_value)
);

// File: tb/sim_seg_addr_unit.sv
`timescale 1ns/1ps
module sim_seg_addr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_we = 1'b0;
  logic [1:0]  seg_wsel = 2'd0;
  logic [15:0] seg_wdata = 16'd0;
  logic [15:0] offset = 16'd0;
  logic [1:0]  kind = 2'd0;
  logic        ovr_valid = 1'b0;
  logic [1:0]  ovr_sel = 2'd0;
  logic [19:0] phys_addr;
  logic [1:0]  seg_used;
  logic [15:0] seg_value;

  int tests = 0;
  int fails = 0;
  int model [4];
  bit done = 0;

  always #4 clk = ~clk;

  seg_addr_unit u0 (
    .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_wsel(seg_wsel),
    .seg_wdata(seg_wdata), .offset(offset), .kind(kind), .ovr_valid(ovr_valid),
    .ovr_sel(ovr_sel), .phys_addr(phys_addr), .seg_used(seg_used),
    .seg_value(seg_value)
  );

  function automatic int pick(input int k, input bit ov, input int os);
    if (k == 0) return 1;
    if (k == 3) return 0;
    if (ov) return os;
    return (k == 1) ? 2 : 3;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit we, input int ws, input int wd, input int off,
                      input int k, input bit ov, input int os, input string req);
    int s;
    int exp_pa;
    @(negedge clk);
    seg_we = we; seg_wsel = 2'(ws); seg_wdata = 16'(wd);
    offset = 16'(off); kind = 2'(k); ovr_valid = ov; ovr_sel = 2'(os);
    #1;
    s = pick(k, ov, os);
    exp_pa = (model[s] * 16 + off) % (1 << 20);
    check({req, " seg"}, int'(seg_used), s);
    check({req, " addr R1"}, int'(phys_addr), exp_pa);
    if (we && rst_n) model[ws] = wd;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    model[0] = 0; model[1] = 'hFFFF; model[2] = 0; model[3] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    kind = 2'd0; #1;
    check("R9 code reset", int'(seg_value), 'hFFFF);
    kind = 2'd3; #1;
    check("R9 extra reset", int'(seg_value), 0);
    kind = 2'd1; #1;
    check("R9 stack reset", int'(seg_value), 0);
    kind = 2'd2; #1;
    check("R9 data reset", int'(seg_value), 0);
    rst_n = 1'b1;

    step(1, 1, 'h1000, 0, 0, 0, 0, "R8 write not yet visible");
    step(0, 0, 0, 0, 0, 0, 0, "R10 fetch");
    check("R10 addr", int'(phys_addr), 'h10000);
    step(1, 0, 'h1111, 'h20, 0, 0, 0, "R8 write extra");
    step(1, 2, 'h2222, 'h30, 1, 0, 0, "R3 stack");
    step(1, 3, 'h3333, 'h40, 2, 0, 0, "R4 data");
    step(0, 0, 0, 'h50, 3, 0, 0, "R5 strdst");
    step(0, 0, 0, 'h60, 1, 0, 0, "R3 stack after write");
    step(0, 0, 0, 'h70, 2, 0, 0, "R4 data after write");
    check("R8 data only", int'(seg_value), 'h3333);
    step(0, 0, 0, 'h10, 1, 1, 1, "R6 stack to code");
    step(0, 0, 0, 'h10, 2, 1, 0, "R6 data to extra");
    step(0, 0, 0, 'h10, 0, 1, 3, "R2 fetch ignores override");
    step(0, 0, 0, 'h10, 3, 1, 2, "R5 strdst ignores override");
    step(1, 1, 'hFFFF, 0, 0, 0, 0, "R8 load top");
    step(0, 0, 0, 'h0010, 0, 0, 0, "R7 wrap");
    check("R7 zero", int'(phys_addr), 0);
    step(0, 0, 0, 'hFFFF, 0, 0, 0, "R7 wrap max");
    check("R7 max", int'(phys_addr), 'h0FFEF);

    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 3);
      step(($urandom_range(0, 3) == 0), $urandom_range(0, 3), $urandom_range(0, 'hFFFF),
           $urandom_range(0, 'hFFFF), k, $urandom_range(0, 1), $urandom_range(0, 3),
           k == 0 ? "R2 random" : k == 3 ? "R5 random" : "R3/R4/R6 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule